// File: doc/BRIEF.md
# Segment-Table Address Translator

This block turns a two-part logical address, a segment number plus an offset within that segment, into a physical address. It enforces the protection rules held in a per-segment descriptor. Software sets a table base and a table length on the configuration inputs. For each translation request the block first bounds the segment number against the table length. It then reads the segment's two-word descriptor from memory through a simple request/response port, and checks the validation flag, the access right and the segment limit. It returns either the relocated physical address or a trap code.

Each descriptor occupies 8 bytes at `tbl_base_i + 8*segment`. The first word is the segment's physical base. The second word carries the segment length in bits 31:4, and in bits 3:0 the flags valid (bit 3), read (bit 2), write (bit 1) and execute (bit 0). Only one translation is in flight at a time. The result is held on a valid/ready handshake until it is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `res_valid_o` and `mem_valid_o` are 0.
- R2: A request whose segment number is greater than or equal to `tbl_len_i` makes no memory read. Its result appears in the cycle right after acceptance, with trap code 1. A table length of 0 traps every segment.
- R3: A request with a legal segment number reads the descriptor as two reads. The first read is at `tbl_base_i + 8*segment`, and the second is at that address plus 4.
- R4: A descriptor whose valid flag (bit 3 of word 1) is 0 gives trap code 2. This check takes precedence over the permission and limit checks.
- R5: Access type encodes as 0 read, 1 write, 2 execute and 3 reserved. A valid descriptor that lacks the matching flag (read bit 2, write bit 1, execute bit 0) gives trap code 3. Type 3 always gives trap code 3. This check takes precedence over the limit check.
- R6: An offset greater than or equal to the limit field (bits 31:4 of word 1) gives trap code 4.
- R7: An access that passes every check gives trap code 0, with `res_paddr_o` equal to the descriptor base plus the offset.
- R8: `res_valid_o`, `res_paddr_o` and `res_trap_o` hold steady until `res_ready_i` is seen. `req_ready_o` stays 0 from acceptance until the result is taken. No memory request is made while idle.
- R9: A memory read request holds `mem_valid_o` and `mem_addr_o` steady until `mem_ready_i` accepts it. The translation result is unaffected by memory back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_i | input | AW | Byte address of the segment table |
| tbl_len_i | input | SEGW+1 | Number of entries in the segment table |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_seg_i | input | SEGW | Segment number |
| req_off_i | input | AW-4 | Offset within the segment |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| mem_valid_o | output | 1 | Descriptor read request |
| mem_ready_i | input | 1 | Memory accepts the read request |
| mem_addr_o | output | AW | Descriptor word address |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | AW | Read data word |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Result consumer ready |
| res_paddr_o | output | AW | Physical address (0 on a trap) |
| res_trap_o | output | 3 | 0 ok, 1 length, 2 invalid, 3 permission, 4 limit |

## Verification
The bench builds the block with SEGW=4 and AW=32, so the table holds at most 16 segments. With this width the full-table length of 16 sits at its boundary: segment 15 is legal and no segment number can exceed it. A length of 0 and a length one above the requested segment are both reachable with a handful of descriptors. The 28-bit limit field lets the bench place offsets at exactly the limit and one below it. A toggling memory ready exercises held read requests under back-pressure.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW   = 32,
  parameter int SEGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   tbl_base_i,
  input  logic [SEGW:0]   tbl_len_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [SEGW-1:0] req_seg_i,
  input  logic [AW-5:0]   req_off_i,
  input  logic [1:0]      req_acc_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [AW-1:0]   mem_rdata_i,
  output logic            res_valid_o,
  input  logic            res_ready_i,
  output logic [AW-1:0]   res_paddr_o,
  output logic [2:0]      res_trap_o
);

  localparam int LIMW = AW - 4;

  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1, S_DONE} state_t;

  state_t          st;
  logic [AW-1:0]   entry_q;
  logic [LIMW-1:0] off_q;
  logic [1:0]      acc_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   paddr_q;
  logic [2:0]      trap_q;

  logic [AW-1:0]   entry_d;
  logic            seg_ok;
  logic            d_valid;
  logic            d_perm;
  logic [LIMW-1:0] d_limit;
  logic [2:0]      trap_d;

  assign entry_d = tbl_base_i + {{(AW-SEGW-3){1'b0}}, req_seg_i, 3'b000};
  assign seg_ok  = {1'b0, req_seg_i} < tbl_len_i;

  assign d_valid = mem_rdata_i[3];
  assign d_limit = mem_rdata_i[AW-1:4];

  always_comb begin
    case (acc_q)
      2'd0:    d_perm = mem_rdata_i[2];
      2'd1:    d_perm = mem_rdata_i[1];
      2'd2:    d_perm = mem_rdata_i[0];
      default: d_perm = 1'b0;
    endcase
  end

  always_comb begin
    if (!d_valid)              trap_d = 3'd2;
    else if (!d_perm)          trap_d = 3'd3;
    else if (off_q >= d_limit) trap_d = 3'd4;
    else                       trap_d = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      entry_q <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      paddr_q <= '0;
      trap_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid_i) begin
          entry_q <= entry_d;
          off_q   <= req_off_i;
          acc_q   <= req_acc_i;
          paddr_q <= '0;
          if (seg_ok) begin
            st <= S_REQ0;
          end else begin
            trap_q <= 3'd1;
            st     <= S_DONE;
          end
        end
        S_REQ0:  if (mem_ready_i) st <= S_WAIT0;
        S_WAIT0: if (mem_rvalid_i) begin
          base_q <= mem_rdata_i;
          st     <= S_REQ1;
        end
        S_REQ1:  if (mem_ready_i) st <= S_WAIT1;
        S_WAIT1: if (mem_rvalid_i) begin
          trap_q  <= trap_d;
          paddr_q <= (trap_d == 3'd0) ? base_q + {4'b0000, off_q} : '0;
          st      <= S_DONE;
        end
        S_DONE:  if (res_ready_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st == S_IDLE);
  assign mem_valid_o = (st == S_REQ0) || (st == S_REQ1);
  assign mem_addr_o  = (st == S_REQ1) ? entry_q + 4 : entry_q;
  assign res_valid_o = (st == S_DONE);
  assign res_paddr_o = paddr_q;
  assign res_trap_o  = trap_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW   = 32,
  parameter int SEGW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SEGW:0]   tbl_len_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [SEGW-1:0] req_seg_i,
  input logic            mem_valid_o,
  input logic            mem_ready_i,
  input logic [AW-1:0]   mem_addr_o,
  input logic            res_valid_o,
  input logic            res_ready_i,
  input logic [AW-1:0]   res_paddr_o,
  input logic [2:0]      res_trap_o
);

  logic          second;
  logic [AW-1:0] first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second  <= 1'b0;
      first_q <= '0;
    end else if (mem_valid_o && mem_ready_i) begin
      if (!second) first_q <= mem_addr_o;
      second <= !second;
    end
  end

  assert_len_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && ({1'b0, req_seg_i} >= tbl_len_i))
      |=> (res_valid_o && res_trap_o == 3'd1 && !mem_valid_o));

  assert_second_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && second) |-> (mem_addr_o == first_q + 4));

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i)
      |=> (res_valid_o && $stable(res_paddr_o) && $stable(res_trap_o)));

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !req_ready_o);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_valid_o);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW), .SEGW(SEGW)) u_chk (.*);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int AW = 32;
  localparam int SEGW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] tbl_base = 32'h100;
  logic [SEGW:0] tbl_len = 5'd8;
  logic req_valid = 0, req_ready;
  logic [SEGW-1:0] req_seg = '0;
  logic [AW-5:0] req_off = '0;
  logic [1:0] req_acc = '0;
  logic mem_valid, mem_ready = 1, mem_rvalid = 0;
  logic [AW-1:0] mem_addr, mem_rdata = '0;
  logic res_valid, res_ready = 0;
  logic [AW-1:0] res_paddr;
  logic [2:0] res_trap;

  int tests = 0, fails = 0;
  bit done = 0;
  bit stall_en = 0;
  int mem_reads = 0;
  logic [AW-1:0] addr_log [0:1];

  logic [31:0] mem [0:255];

  always #5 clk = ~clk;

  seg_xlate #(.AW(AW), .SEGW(SEGW)) u0 (
    .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base), .tbl_len_i(tbl_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_seg_i(req_seg),
    .req_off_i(req_off), .req_acc_i(req_acc),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_paddr_o(res_paddr), .res_trap_o(res_trap));

  always @(posedge clk) begin
    mem_rvalid <= mem_valid && mem_ready;
    mem_rdata  <= mem[mem_addr[9:2]];
    if (mem_valid && mem_ready) begin
      addr_log[mem_reads % 2] <= mem_addr;
      mem_reads <= mem_reads + 1;
    end
    mem_ready <= stall_en ? ~mem_ready : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_desc(input int seg, input logic [31:0] base, input logic [27:0] lim, input logic [3:0] flags);
    mem[64 + seg*2]     = base;
    mem[64 + seg*2 + 1] = {lim, flags};
  endtask

  task automatic run(input logic [SEGW-1:0] seg, input logic [27:0] off, input logic [1:0] acc,
                     input int hold, output logic [31:0] pa, output logic [2:0] tr, output int cyc);
    @(negedge clk);
    req_seg = seg; req_off = off; req_acc = acc; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!res_valid) begin
      @(negedge clk);
      cyc++;
    end
    pa = res_paddr; tr = res_trap;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(res_valid && res_paddr == pa && res_trap == tr, "R8 held result", {29'd0, res_trap}, {29'd0, tr});
      check(!req_ready, "R8 no new accept", {31'd0, req_ready}, 32'd0);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check(!res_valid && req_ready, "R8 result released", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check(req_ready == 1, "R1 req_ready", {31'd0, req_ready}, 1);
    check(res_valid == 0, "R1 res_valid", {31'd0, res_valid}, 0);
    check(mem_valid == 0, "R1 mem_valid", {31'd0, mem_valid}, 0);
  endtask

  task automatic t_legal;
    logic [31:0] pa; logic [2:0] tr; int c, r0;
    r0 = mem_reads;
    run(4'd2, 28'h10, 2'd0, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h2000_0010, "R7 read legal", pa, 32'h2000_0010);
    check(mem_reads == r0 + 2, "R3 two reads", mem_reads, r0 + 2);
    check(addr_log[r0 % 2] == 32'h110, "R3 word0 addr", addr_log[r0 % 2], 32'h110);
    check(addr_log[(r0 + 1) % 2] == 32'h114, "R3 word1 addr", addr_log[(r0 + 1) % 2], 32'h114);
    run(4'd5, 28'h7ff, 2'd1, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h0005_07ff, "R7 write legal", pa, 32'h0005_07ff);
    run(4'd6, 28'h3, 2'd2, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h8000_0003, "R7 exec legal", pa, 32'h8000_0003);
  endtask

  task automatic t_len;
    logic [31:0] pa; logic [2:0] tr; int c, r0;
    r0 = mem_reads;
    run(4'd8, 28'h0, 2'd0, 0, pa, tr, c);
    check(tr == 1, "R2 seg==len trap", {29'd0, tr}, 1);
    check(c == 1, "R2 one-cycle trap", c, 1);
    check(mem_reads == r0, "R2 no memory read", mem_reads, r0);
    run(4'd7, 28'h0, 2'd0, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h0700_0000, "R2 seg==len-1 legal", pa, 32'h0700_0000);
    tbl_len = 5'd0;
    run(4'd0, 28'h0, 2'd0, 0, pa, tr, c);
    check(tr == 1, "R2 zero length traps", {29'd0, tr}, 1);
    tbl_len = 5'd16;
    run(4'd15, 28'h4, 2'd0, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h0F00_0004, "R2 full table seg 15", pa, 32'h0F00_0004);
    tbl_len = 5'd8;
  endtask

  task automatic t_invalid;
    logic [31:0] pa; logic [2:0] tr; int c;
    run(4'd3, 28'hFFFF, 2'd1, 0, pa, tr, c);
    check(tr == 2 && pa == 0, "R4 invalid before perm/limit", {29'd0, tr}, 2);
  endtask

  task automatic t_perm;
    logic [31:0] pa; logic [2:0] tr; int c;
    run(4'd1, 28'hFFFF, 2'd1, 0, pa, tr, c);
    check(tr == 3, "R5 write to read-only, before limit", {29'd0, tr}, 3);
    run(4'd1, 28'h1, 2'd2, 0, pa, tr, c);
    check(tr == 3, "R5 exec without X", {29'd0, tr}, 3);
    run(4'd4, 28'h1, 2'd3, 0, pa, tr, c);
    check(tr == 3, "R5 reserved type", {29'd0, tr}, 3);
  endtask

  task automatic t_limit;
    logic [31:0] pa; logic [2:0] tr; int c;
    run(4'd4, 28'h100, 2'd0, 0, pa, tr, c);
    check(tr == 4 && pa == 0, "R6 offset==limit", {29'd0, tr}, 4);
    run(4'd4, 28'hFF, 2'd2, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h4000_00FF, "R6 offset==limit-1 ok", pa, 32'h4000_00FF);
  endtask

  task automatic t_hold;
    logic [31:0] pa; logic [2:0] tr; int c;
    run(4'd2, 28'h20, 2'd0, 5, pa, tr, c);
    check(tr == 0 && pa == 32'h2000_0020, "R8 held value", pa, 32'h2000_0020);
  endtask

  task automatic t_stall;
    logic [31:0] pa; logic [2:0] tr; int c, r0;
    stall_en = 1;
    r0 = mem_reads;
    run(4'd5, 28'h11, 2'd1, 0, pa, tr, c);
    check(tr == 0 && pa == 32'h0005_0011, "R9 stalled result", pa, 32'h0005_0011);
    check(addr_log[r0 % 2] == 32'h128 && addr_log[(r0 + 1) % 2] == 32'h12C, "R9 stalled addrs",
          addr_log[(r0 + 1) % 2], 32'h12C);
    stall_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    set_desc(1, 32'h1000_0000, 28'h100, 4'b1100);
    set_desc(2, 32'h2000_0000, 28'h1000, 4'b1100);
    set_desc(3, 32'h3000_0000, 28'h10, 4'b0111);
    set_desc(4, 32'h4000_0000, 28'h100, 4'b1111);
    set_desc(5, 32'h0005_0000, 28'h800, 4'b1010);
    set_desc(6, 32'h8000_0000, 28'h4, 4'b1001);
    set_desc(7, 32'h0700_0000, 28'h1, 4'b1100);
    set_desc(15, 32'h0F00_0000, 28'h8, 4'b1100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_legal();
    t_len();
    t_invalid();
    t_perm();
    t_limit();
    t_hold();
    t_stall();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule